// File: doc/BRIEF.md
# 2B4B DC-Balanced Line Encoder

This block merges two serial streams of different rates into one coded line. A main-data stream runs at twice the word rate and a supervisory stream runs at the word rate. For every word period the block takes two main bits and one supervisory bit and forms a 3-bit dataword. It maps that dataword to a 4-bit codeword and sends the codeword bit-serially at four times the word rate. All of this runs on a single bit clock at the coded rate. The nominal rates are 2.048 Mbps for main data, 1.024 Mbps for supervisory data and 4.096 Mbps for the line.

Six of the eight datawords map to codewords with two ones and two zeros. The all-zero and all-one datawords have no balanced image. Each of them alternates between a pair of complementary codewords, steered by its own toggle flag, so that a run of such words carries no net DC. The four codewords that would permit long runs of equal bits are never sent.

A 2-bit phase counter divides every word period into four bit slots. The main input is sampled in slot 0 and again in slot 2. The supervisory input is sampled in slot 2. The new codeword is loaded at the slot-2 edge and appears both on the parallel output and, one bit per clock, on the serial line.

Top module: `dcb_line_encoder`

## Requirements
- R1: After reset is released, the first rising edge is phase 0. The main bit sampled at phase 0 becomes dataword bit 1 (the middle bit). The main bit and the supervisory bit sampled at phase 2 become bit 0 and bit 2 (the MSB). The dataword is {sup, main@ph0, main@ph2}.
- R2: The balanced datawords map as follows: 001→1001, 010→1010, 011→0011, 100→1100, 101→0101, 110→0110. Codewords are written MSB (bit 3) first.
- R3: Dataword 000 sends 0010 when its flag is clear and 1101 when it is set. Its flag flips on every 000 word.
- R4: Dataword 111 sends 1011 when its flag is clear and 0100 when it is set. Its flag flips on every 111 word.
- R5: The two flags are independent. A 000 word does not change the 111 flag, and a 111 word does not change the 000 flag. Balanced words change neither flag.
- R6: The codewords 0001, 1000, 1110 and 0111 never appear on the parallel output.
- R7: The parallel codeword changes only at the phase-2 edge and is held for four clocks. The serial line carries bit 3, 2, 1 and 0 of that codeword, one per clock, starting in the cycle right after the load edge (MSB first, the default).
- R8: While reset is high, the parallel code is 0000, the serial line is 0, both flags are clear and the phase is 0. After reset, the first 000 sends 0010 and the first 111 sends 1011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock at the coded line rate |
| rst | input | 1 | Synchronous active-high reset |
| main_bit | input | 1 | Main-data serial bit, each held for two clocks |
| sup_bit | input | 1 | Supervisory serial bit, each held for four clocks |
| line_out | output | 1 | Serial coded stream |
| code_out | output | 4 | Current parallel codeword |

## Verification
The bench repeats the all-zero and all-one datawords back to back and also interleaves them. A design that shared one flag between the two, or flipped a flag on the wrong word, would send the wrong member of a complementary pair. A mid-stream reset after one unbalanced word shows whether the flags clear; a design that kept them would start the next word with the complement. The fixed-map patterns 001, 010 and 100 separate the three dataword positions, so a swap of the two main bits or a misplaced supervisory bit yields a different balanced codeword. The serial line is compared bit by bit against the codeword loaded a word earlier, which catches a reversed or shifted bit order. A long pseudo-random stream then checks all of these together, and also confirms that no forbidden codeword is sent.

// File: rtl/lce_pkg.sv
package lce_pkg;
   localparam int CODE_W = 4;
   localparam int DW_W   = 3;
   typedef logic [CODE_W-1:0] code_t;
   typedef logic [DW_W-1:0]   dw_t;

   // Complementary pairs for the two unbalanced datawords
   localparam code_t ZERO_CODE_A = 4'b0010;
   localparam code_t ZERO_CODE_B = 4'b1101;
   localparam code_t ONES_CODE_A = 4'b1011;
   localparam code_t ONES_CODE_B = 4'b0100;

   function automatic code_t lce_map(input dw_t dw, input logic zflag, input logic oflag);
      code_t c;
      case (dw)
         3'b000:  c = zflag ? ZERO_CODE_B : ZERO_CODE_A;
         3'b001:  c = 4'b1001;
         3'b010:  c = 4'b1010;
         3'b011:  c = 4'b0011;
         3'b100:  c = 4'b1100;
         3'b101:  c = 4'b0101;
         3'b110:  c = 4'b0110;
         default: c = oflag ? ONES_CODE_B : ONES_CODE_A;
      endcase
      return c;
   endfunction
endpackage

// File: rtl/lce_wordgather.sv
module lce_wordgather #(
   parameter int SLOTS = 4
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     main_bit,
   input  logic                     sup_bit,
   output logic [$clog2(SLOTS)-1:0] phase,
   output logic                     load,
   output lce_pkg::dw_t             dataword
);
   localparam int PH_W = $clog2(SLOTS);
   localparam logic [PH_W-1:0] LOAD_PH = PH_W'(SLOTS / 2);

   logic [PH_W-1:0] phase_q;
   logic            first_main_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q      <= '0;
         first_main_q <= 1'b0;
      end else begin
         phase_q <= phase_q + 1'b1;
         if (phase_q == '0) first_main_q <= main_bit;
      end
   end

   assign phase    = phase_q;
   assign load     = (phase_q == LOAD_PH);
   assign dataword = {sup_bit, first_main_q, main_bit};
endmodule

// File: rtl/lce_disparity.sv
module lce_disparity (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  lce_pkg::dw_t dataword,
   output logic         zero_flag,
   output logic         one_flag
);
   logic [1:0] flag_q;

   // Flag 0 follows the all-zero word, flag 1 the all-one word
   for (genvar g = 0; g < 2; g++) begin : g_flag
      localparam lce_pkg::dw_t TARGET = (g == 0) ? '0 : '1;
      always_ff @(posedge clk) begin
         if (rst)                             flag_q[g] <= 1'b0;
         else if (load && dataword == TARGET) flag_q[g] <= ~flag_q[g];
      end
   end

   assign zero_flag = flag_q[0];
   assign one_flag  = flag_q[1];
endmodule

// File: rtl/lce_serializer.sv
module lce_serializer #(
   parameter int SLOTS     = 4,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     load,
   input  logic [$clog2(SLOTS)-1:0] phase,
   input  lce_pkg::code_t           code_in,
   output lce_pkg::code_t           code_q,
   output logic                     ser
);
   localparam int PH_W = $clog2(SLOTS);

   logic [PH_W-1:0] slot;
   logic [PH_W-1:0] idx;

   always_ff @(posedge clk) begin
      if (rst)       code_q <= '0;
      else if (load) code_q <= code_in;
   end

   // The slot after the load edge carries the first bit
   assign slot = phase + 1'b1;

   if (MSB_FIRST) begin : g_msb
      assign idx = ~slot;
   end else begin : g_lsb
      assign idx = slot;
   end

   assign ser = code_q[idx];
endmodule

// File: rtl/dcb_line_encoder.sv
module dcb_line_encoder #(
   parameter bit SERIAL_MSB_FIRST = 1'b1
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       main_bit,
   input  logic       sup_bit,
   output logic       line_out,
   output logic [3:0] code_out
);
   localparam int SLOTS = lce_pkg::CODE_W;
   localparam int PH_W  = $clog2(SLOTS);

   initial begin
      assert (SLOTS == (1 << PH_W) && SLOTS == 2 * (lce_pkg::DW_W - 1))
         else $error("codeword width must be a power of two matching the dataword");
   end

   logic [PH_W-1:0] phase;
   logic            load;
   lce_pkg::dw_t    dataword;
   logic            zero_flag;
   logic            one_flag;
   lce_pkg::code_t  next_code;
   lce_pkg::code_t  code_q;

   lce_wordgather #(.SLOTS(SLOTS)) u_gather (
      .clk(clk), .rst(rst), .main_bit(main_bit), .sup_bit(sup_bit),
      .phase(phase), .load(load), .dataword(dataword)
   );

   lce_disparity u_disp (
      .clk(clk), .rst(rst), .load(load), .dataword(dataword),
      .zero_flag(zero_flag), .one_flag(one_flag)
   );

   assign next_code = lce_pkg::lce_map(dataword, zero_flag, one_flag);

   lce_serializer #(.SLOTS(SLOTS), .MSB_FIRST(SERIAL_MSB_FIRST)) u_ser (
      .clk(clk), .rst(rst), .load(load), .phase(phase),
      .code_in(next_code), .code_q(code_q), .ser(line_out)
   );

   assign code_out = code_q;
endmodule

// File: rtl/lce_checker.sv
module lce_checker #(
   parameter bit MSB_FIRST = 1'b1
) (
   input logic       clk,
   input logic       rst,
   input logic [1:0] phase,
   input logic       zflag,
   input logic       oflag,
   input logic [3:0] code,
   input logic       ser
);
   AST_NO_FORBIDDEN: assert property (@(posedge clk) disable iff (rst)
      !(code == 4'b0001 || code == 4'b1000 || code == 4'b1110 || code == 4'b0111)); // R6

   AST_CODE_HELD: assert property (@(posedge clk) disable iff (rst)
      (phase != 2'd2) |=> $stable(code)); // R7

   AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (rst)
      (phase != 2'd2) |=> ($stable(zflag) && $stable(oflag))); // R5

   AST_ZERO_PAIR_A: assert property (@(posedge clk) disable iff (rst)
      (phase == 2'd3 && code == 4'b0010) |-> zflag); // R3
   AST_ZERO_PAIR_B: assert property (@(posedge clk) disable iff (rst)
      (phase == 2'd3 && code == 4'b1101) |-> !zflag); // R3

   AST_ONES_PAIR_A: assert property (@(posedge clk) disable iff (rst)
      (phase == 2'd3 && code == 4'b1011) |-> oflag); // R4
   AST_ONES_PAIR_B: assert property (@(posedge clk) disable iff (rst)
      (phase == 2'd3 && code == 4'b0100) |-> !oflag); // R4

   if (MSB_FIRST) begin : g_ser_chk
      AST_FIRST_BIT: assert property (@(posedge clk) disable iff (rst)
         (phase == 2'd3) |-> (ser == code[3])); // R7
   end

   AST_RESET_STATE: assert property (@(posedge clk)
      rst |=> (code == 4'b0000 && phase == 2'd0 && !zflag && !oflag && !ser)); // R8
endmodule

bind dcb_line_encoder lce_checker #(.MSB_FIRST(SERIAL_MSB_FIRST)) u_chk (
   .clk(clk), .rst(rst), .phase(phase), .zflag(zero_flag), .oflag(one_flag),
   .code(code_out), .ser(line_out)
);

// File: tb/dcb_line_encoder_tb.sv
module dcb_line_encoder_tb;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       main_bit = 1'b0;
   logic       sup_bit = 1'b0;
   logic       line_out;
   logic [3:0] code_out;

   int checks = 0;
   int fails  = 0;

   // Bench reference state
   logic       m_zf = 1'b0;
   logic       m_of = 1'b0;
   logic [3:0] prev_code = 4'b0000;
   bit         prev_valid = 1'b0;

   always #2 clk = ~clk; // 250 MHz

   dcb_line_encoder u_dut (
      .clk(clk), .rst(rst), .main_bit(main_bit), .sup_bit(sup_bit),
      .line_out(line_out), .code_out(code_out)
   );

   task automatic chk(input bit ok, input string req, input logic [3:0] act, input logic [3:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   function automatic logic [3:0] ref_code(input logic [2:0] dw);
      logic [3:0] c;
      case (dw)
         3'b001: c = 4'b1001;
         3'b010: c = 4'b1010;
         3'b011: c = 4'b0011;
         3'b100: c = 4'b1100;
         3'b101: c = 4'b0101;
         3'b110: c = 4'b0110;
         3'b000: c = m_zf ? 4'b1101 : 4'b0010;
         default: c = m_of ? 4'b0100 : 4'b1011;
      endcase
      return c;
   endfunction

   // Called at a negedge; returns at a negedge, four clocks later
   task automatic send_word(input logic [2:0] dw, input string req);
      logic [3:0] exp;
      exp = ref_code(dw);
      if (dw == 3'b000) m_zf = ~m_zf;
      if (dw == 3'b111) m_of = ~m_of;
      for (int k = 0; k < 4; k++) begin
         if (k < 3 && prev_valid) begin
            chk(line_out == prev_code[2-k], {"R7 serial bit ", req}, {3'b0, line_out}, {3'b0, prev_code[2-k]});
            chk(code_out == prev_code, {"R7 code held ", req}, code_out, prev_code);
         end
         if (k == 3) begin
            chk(code_out == exp, req, code_out, exp);
            chk(line_out == exp[3], {"R7 first serial bit ", req}, {3'b0, line_out}, {3'b0, exp[3]});
            chk(!(code_out inside {4'b0001, 4'b1000, 4'b1110, 4'b0111}), "R6 forbidden code", code_out, exp);
         end
         main_bit = (k < 2) ? dw[1] : dw[0];
         sup_bit  = dw[2];
         @(posedge clk);
         @(negedge clk);
      end
      prev_code  = exp;
      prev_valid = 1'b1;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      repeat (3) @(negedge clk);
      chk(code_out == 4'b0000, "R8 reset code", code_out, 4'b0000);
      chk(line_out == 1'b0, "R8 reset serial", {3'b0, line_out}, 4'b0000);
      rst = 1'b0;
      m_zf = 1'b0;
      m_of = 1'b0;
      prev_valid = 1'b0;
   endtask

   task automatic t_fixed_maps();
      do_reset();
      send_word(3'b001, "R1 R2 map 001");
      send_word(3'b010, "R1 R2 map 010");
      send_word(3'b100, "R1 R2 map 100");
      send_word(3'b011, "R2 map 011");
      send_word(3'b101, "R2 map 101");
      send_word(3'b110, "R2 map 110");
   endtask

   task automatic t_zero_alt();
      do_reset();
      for (int i = 0; i < 3; i++) send_word(3'b000, "R3 zero word alternation");
   endtask

   task automatic t_ones_alt();
      do_reset();
      for (int i = 0; i < 3; i++) send_word(3'b111, "R4 ones word alternation");
   endtask

   task automatic t_interleave();
      do_reset();
      send_word(3'b000, "R5 interleave");
      send_word(3'b111, "R5 interleave");
      send_word(3'b111, "R5 interleave");
      send_word(3'b011, "R5 interleave");
      send_word(3'b000, "R5 interleave");
      send_word(3'b111, "R5 interleave");
      send_word(3'b101, "R5 interleave");
   endtask

   task automatic t_reset_mid();
      do_reset();
      send_word(3'b000, "R8 pre-reset zero");
      send_word(3'b111, "R8 pre-reset ones");
      do_reset();
      send_word(3'b000, "R8 first zero after reset");
      send_word(3'b111, "R8 first ones after reset");
   endtask

   task automatic t_stream();
      logic [8:0] lfsr = 9'h1A5;
      do_reset();
      for (int i = 0; i < 300; i++) begin
         send_word(lfsr[2:0], "R6 R7 pseudo-random stream");
         for (int s = 0; s < 3; s++) lfsr = {lfsr[7:0], lfsr[8] ^ lfsr[4]};
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      t_fixed_maps();
      t_zero_alt();
      t_ones_alt();
      t_interleave();
      t_reset_mid();
      t_stream();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule